// File: doc/BRIEF.md
# Column Hit Buffer Controller

This block sits at the foot of one pixel column. It keeps a free-running 12-bit time-stamp counter and drives its Gray-coded value up the column. Whenever the column reports a pending hit, a small sequencer runs a fixed scan over the shared column bus. It holds the pixels frozen, pulses the read command, reads the leading-edge stamp, reads the trailing-edge stamp, and then clears the pixel. The pixel address and both stamps go into a 16-entry first-in first-out store as one record.

The readout controller can ask for an end-of-column event marker. The block then places a dummy pixel in the scan. When the sequencer serves it, a "dummy seen" flag is raised and held until the controller clears it. A framing record is written into the store in the same way as a hit. The store shows its oldest record at all times. A read strobe removes that record. The store reports empty, almost-full and full, and a busy output signals back-pressure. A write into a full store and a read from an empty store are both dropped, and each sets its own sticky error flag.

Sequencer states are IDLE, FREEZE, CMD, LE, TE, CLEAR and EVENT. The transitions are:
- IDLE→EVENT when a marker is pending.
- IDLE→FREEZE when a hit is pending, no marker is pending and almost-full is low.
- FREEZE→CMD→LE→TE→CLEAR→IDLE, one cycle each.
- EVENT→IDLE after one cycle.

Top module: `eoc_hit_buffer`

## Requirements
- R1: `ts_gray` is 0 during reset. After n clock edges since reset release it equals g(n mod 4096), where g(x) = x XOR (x >> 1). Consecutive values differ in exactly one bit.
- R2: A scan drives `freeze`, then `read_cmd`, then `read_le`, then `read_te`, then `clear_hit`. Each strobe is high for one cycle, in consecutive cycles, and `freeze` stays high throughout. One scan serves one pixel.
- R3: A hit record is {pixel id, leading stamp, trailing stamp}. These are the `col_id`, `col_le` and `col_te` values presented during the scan. Records leave in write order. `rd_id`, `rd_le` and `rd_te` show the oldest record whenever the store is not empty, and a high `rd_en` removes it at the clock edge.
- R4: The store holds 16 records. `empty` is high at 0 records, `full` at 16, and `almost_full` and `busy` at 14 or more. A read and a write in the same cycle leave the occupancy unchanged.
- R5: No scan starts at an edge where occupancy is 14 or more. `freeze` is high whenever occupancy is 14 or more.
- R6: A high `evt_req` is accepted only when no marker is pending, and is otherwise ignored. A pending marker is served before the next scan starts. Its record is {all-ones id 127, the `ts_gray` value at the accepting edge, an event number starting at 0 after reset}. It is written even when almost-full is high.
- R7: `dp_present` rises when the marker is served. It stays high until a cycle with `dp_clear` high, and falls at that edge.
- R8: A write while `full` is high is dropped, even if a read happens in the same cycle, and sets `ovf_err`. `ovf_err` stays high until reset.
- R9: A read while `empty` is high is ignored, even if a write happens in the same cycle, and sets `unf_err`. `unf_err` stays high until reset.
- R10: During reset, `empty` is high and all other flags and strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_gray | output | 12 | Gray-coded time stamp sent up the column |
| hit_pending | input | 1 | At least one pixel in the column holds a hit |
| col_id | input | 7 | Address of the pixel currently on the bus |
| col_le | input | 12 | Leading-edge stamp on the bus |
| col_te | input | 12 | Trailing-edge stamp on the bus |
| freeze | output | 1 | Hold pixel state |
| read_cmd | output | 1 | Select the winning pixel onto the bus |
| read_le | output | 1 | Leading-edge stamp read strobe |
| read_te | output | 1 | Trailing-edge stamp read strobe |
| clear_hit | output | 1 | Release the served pixel |
| evt_req | input | 1 | Request an end-of-column event marker |
| dp_present | output | 1 | Dummy pixel served, held until cleared |
| dp_clear | input | 1 | Clear `dp_present` |
| rd_en | input | 1 | Remove the oldest record |
| rd_id | output | 7 | Oldest record: pixel id |
| rd_le | output | 12 | Oldest record: leading stamp |
| rd_te | output | 12 | Oldest record: trailing stamp |
| empty | output | 1 | No records stored |
| almost_full | output | 1 | 14 or more records |
| full | output | 1 | 16 records |
| busy | output | 1 | Back-pressure to the readout |
| ovf_err | output | 1 | Sticky dropped-write flag |
| unf_err | output | 1 | Sticky empty-read flag |

## Verification
The store can take a write, from the CLEAR or EVENT state, and a read from the readout at the same clock edge. This case decides the occupancy, the flags and the drop rules. The bench provokes it by running the read strobe at several random densities while hits and marker requests arrive at random. It also runs a phase that fills the store with markers and then reads it dry. A bench model predicts every write from the `clear_hit` and `dp_present` pulses seen one half-cycle earlier, applies the pre-edge occupancy rules of R4, R8 and R9, and compares the flags and the oldest record every cycle.

// File: rtl/eoc_pkg.sv
package eoc_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FREEZE,
        SQ_CMD,
        SQ_LE,
        SQ_TE,
        SQ_CLEAR,
        SQ_EVENT
    } seq_state_t;

endpackage

// File: rtl/eoc_gray_ts.sv
module eoc_gray_ts #(
    parameter int TS_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] gray_o
);

    logic [TS_W-1:0] bin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bin_q <= '0;
        else        bin_q <= bin_q + 1'b1;
    end

    assign gray_o = bin_q ^ (bin_q >> 1);

    // R1: one bit flips per step
    p_gray_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(gray_o ^ $past(gray_o)) == 1));

endmodule

// File: rtl/eoc_hit_fifo.sv
module eoc_hit_fifo #(
    parameter int W        = 31,
    parameter int DEPTH    = 16,
    parameter int AF_LEVEL = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         rd_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         af_o,
    output logic         full_o,
    output logic         ovf_o,
    output logic         unf_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] count_q;
    logic          wr_ok, rd_ok;

    assign empty_o = (count_q == '0);
    assign full_o  = (count_q == CW'(DEPTH));
    assign af_o    = (count_q >= CW'(AF_LEVEL));
    assign wr_ok   = wr_i && !full_o;
    assign rd_ok   = rd_i && !empty_o;
    assign head_o  = mem[rptr_q];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr_q] <= wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
            ovf_o   <= 1'b0;
            unf_o   <= 1'b0;
        end else begin
            if (wr_ok) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            if (rd_ok) rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            unique case ({wr_ok, rd_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
            if (wr_i && full_o)  ovf_o <= 1'b1;
            if (rd_i && empty_o) unf_o <= 1'b1;
        end
    end

    // R4: occupancy bounded by the depth
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));
    // R8: a write into a full store without a read changes nothing
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && wr_i && !rd_i) |=> (full_o && $stable(wptr_q)));
    // R9: a read from an empty store without a write changes nothing
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && rd_i && !wr_i) |=> (empty_o && $stable(rptr_q)));
    // R8: sticky overflow
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
    // R9: sticky underflow
    p_unf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> unf_o);

endmodule

// File: rtl/eoc_col_seq.sv
module eoc_col_seq
    import eoc_pkg::*;
#(
    parameter int ID_W = 7,
    parameter int TS_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hit_pending_i,
    input  logic [ID_W-1:0]          col_id_i,
    input  logic [TS_W-1:0]          col_le_i,
    input  logic [TS_W-1:0]          col_te_i,
    input  logic                     evt_req_i,
    input  logic                     dp_clear_i,
    input  logic                     af_i,
    input  logic [TS_W-1:0]          stamp_i,
    output logic                     freeze_o,
    output logic                     read_cmd_o,
    output logic                     read_le_o,
    output logic                     read_te_o,
    output logic                     clear_hit_o,
    output logic                     dp_present_o,
    output logic                     wr_o,
    output logic [ID_W+2*TS_W-1:0]   wr_rec_o
);

    localparam logic [ID_W-1:0] DUMMY_ID = '1;

    seq_state_t      state_q, state_d;
    logic [ID_W-1:0] cap_id_q;
    logic [TS_W-1:0] cap_le_q, cap_te_q, evt_stamp_q, evt_num_q;
    logic            pend_q, scan_act, enter_evt;

    assign enter_evt = (state_q == SQ_IDLE) && pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (pend_q)                        state_d = SQ_EVENT;
                else if (hit_pending_i && !af_i)   state_d = SQ_FREEZE;
            end
            SQ_FREEZE: state_d = SQ_CMD;
            SQ_CMD:    state_d = SQ_LE;
            SQ_LE:     state_d = SQ_TE;
            SQ_TE:     state_d = SQ_CLEAR;
            SQ_CLEAR:  state_d = SQ_IDLE;
            SQ_EVENT:  state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        scan_act    = 1'b0;
        read_cmd_o  = 1'b0;
        read_le_o   = 1'b0;
        read_te_o   = 1'b0;
        clear_hit_o = 1'b0;
        wr_o        = 1'b0;
        wr_rec_o    = {cap_id_q, cap_le_q, cap_te_q};
        unique case (state_q)
            SQ_IDLE:   ;
            SQ_FREEZE: scan_act = 1'b1;
            SQ_CMD:    begin scan_act = 1'b1; read_cmd_o = 1'b1; end
            SQ_LE:     begin scan_act = 1'b1; read_le_o  = 1'b1; end
            SQ_TE:     begin scan_act = 1'b1; read_te_o  = 1'b1; end
            SQ_CLEAR:  begin scan_act = 1'b1; clear_hit_o = 1'b1; wr_o = 1'b1; end
            SQ_EVENT:  begin
                wr_o     = 1'b1;
                wr_rec_o = {DUMMY_ID, evt_stamp_q, evt_num_q};
            end
            default:   ;
        endcase
        freeze_o = scan_act || af_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_id_q     <= '0;
            cap_le_q     <= '0;
            cap_te_q     <= '0;
            evt_stamp_q  <= '0;
            evt_num_q    <= '0;
            pend_q       <= 1'b0;
            dp_present_o <= 1'b0;
        end else begin
            if (state_q == SQ_LE) begin
                cap_id_q <= col_id_i;
                cap_le_q <= col_le_i;
            end
            if (state_q == SQ_TE) cap_te_q <= col_te_i;
            if (evt_req_i && !pend_q) begin
                pend_q      <= 1'b1;
                evt_stamp_q <= stamp_i;
            end else if (enter_evt) begin
                pend_q <= 1'b0;
            end
            if (enter_evt)       dp_present_o <= 1'b1;
            else if (dp_clear_i) dp_present_o <= 1'b0;
            if (state_q == SQ_EVENT) evt_num_q <= evt_num_q + 1'b1;
        end
    end

    // R2: strobe ordering
    p_le_after_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        read_le_o |-> $past(read_cmd_o));
    p_te_after_le_r2: assert property (@(posedge clk) disable iff (!rst_n)
        read_te_o |-> $past(read_le_o));
    p_clear_after_te_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_hit_o |-> $past(read_te_o));
    // R5: a scan only starts from an edge with occupancy below the level
    p_scan_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_FREEZE) |-> $past(!af_i));
    // R7: the served marker is flagged
    p_dp_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_EVENT) |-> dp_present_o);

endmodule

// File: rtl/eoc_hit_buffer.sv
module eoc_hit_buffer #(
    parameter int ID_W     = 7,
    parameter int TS_W     = 12,
    parameter int DEPTH    = 16,
    parameter int AF_LEVEL = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts_gray,
    input  logic            hit_pending,
    input  logic [ID_W-1:0] col_id,
    input  logic [TS_W-1:0] col_le,
    input  logic [TS_W-1:0] col_te,
    output logic            freeze,
    output logic            read_cmd,
    output logic            read_le,
    output logic            read_te,
    output logic            clear_hit,
    input  logic            evt_req,
    output logic            dp_present,
    input  logic            dp_clear,
    input  logic            rd_en,
    output logic [ID_W-1:0] rd_id,
    output logic [TS_W-1:0] rd_le,
    output logic [TS_W-1:0] rd_te,
    output logic            empty,
    output logic            almost_full,
    output logic            full,
    output logic            busy,
    output logic            ovf_err,
    output logic            unf_err
);

    localparam int REC_W = ID_W + 2 * TS_W;

    logic             wr;
    logic [REC_W-1:0] wr_rec, head;
    logic             af;

    eoc_gray_ts #(.TS_W(TS_W)) u_ts (
        .clk    (clk),
        .rst_n  (rst_n),
        .gray_o (ts_gray)
    );

    eoc_col_seq #(.ID_W(ID_W), .TS_W(TS_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .hit_pending_i (hit_pending),
        .col_id_i      (col_id),
        .col_le_i      (col_le),
        .col_te_i      (col_te),
        .evt_req_i     (evt_req),
        .dp_clear_i    (dp_clear),
        .af_i          (af),
        .stamp_i       (ts_gray),
        .freeze_o      (freeze),
        .read_cmd_o    (read_cmd),
        .read_le_o     (read_le),
        .read_te_o     (read_te),
        .clear_hit_o   (clear_hit),
        .dp_present_o  (dp_present),
        .wr_o          (wr),
        .wr_rec_o      (wr_rec)
    );

    eoc_hit_fifo #(.W(REC_W), .DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr),
        .wr_data_i (wr_rec),
        .rd_i      (rd_en),
        .head_o    (head),
        .empty_o   (empty),
        .af_o      (af),
        .full_o    (full),
        .ovf_o     (ovf_err),
        .unf_o     (unf_err)
    );

    assign almost_full          = af;
    assign busy                 = af;
    assign {rd_id, rd_le, rd_te} = head;

    // R5: back-pressure always comes with frozen pixels
    p_busy_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> freeze);
    // R4: full implies almost-full
    p_full_af_r4: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> almost_full);

endmodule

// File: tb/eoc_hit_buffer_tb_top.sv
module eoc_hit_buffer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ID_W  = 7;
    localparam int TS_W  = 12;
    localparam int DEPTH = 16;
    localparam int AFL   = 14;
    localparam int REC_W = ID_W + 2 * TS_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [TS_W-1:0] ts_gray;
    logic            hit_pending = 1'b0;
    logic [ID_W-1:0] col_id = '0;
    logic [TS_W-1:0] col_le = '0, col_te = '0;
    logic            freeze, read_cmd, read_le, read_te, clear_hit;
    logic            evt_req = 1'b0, dp_present, dp_clear = 1'b0, rd_en = 1'b0;
    logic [ID_W-1:0] rd_id;
    logic [TS_W-1:0] rd_le, rd_te;
    logic            empty, almost_full, full, busy, ovf_err, unf_err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eoc_hit_buffer #(.ID_W(ID_W), .TS_W(TS_W), .DEPTH(DEPTH), .AF_LEVEL(AFL)) dut_i (
        .clk(clk), .rst_n(rst_n), .ts_gray(ts_gray), .hit_pending(hit_pending),
        .col_id(col_id), .col_le(col_le), .col_te(col_te), .freeze(freeze),
        .read_cmd(read_cmd), .read_le(read_le), .read_te(read_te),
        .clear_hit(clear_hit), .evt_req(evt_req), .dp_present(dp_present),
        .dp_clear(dp_clear), .rd_en(rd_en), .rd_id(rd_id), .rd_le(rd_le),
        .rd_te(rd_te), .empty(empty), .almost_full(almost_full), .full(full),
        .busy(busy), .ovf_err(ovf_err), .unf_err(unf_err)
    );

    int n_checks = 0;
    int n_fail   = 0;
    logic [REC_W-1:0] colq[$];
    logic [REC_W-1:0] mq[$];
    bit   m_ovf = 0, m_unf = 0, pend = 0;
    bit   dp_prev = 0, clr_prev = 0;
    int   evt_cnt = 0, gcnt = 0, size1 = 0, size2 = 0;
    int   h1 = 0, h2 = 0, h3 = 0;
    logic [TS_W-1:0] pend_stamp = '0;

    function automatic logic [TS_W-1:0] gray_of(int n);
        logic [TS_W-1:0] b = TS_W'(n);
        return b ^ (b >> 1);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive_col();
        hit_pending = (colq.size() > 0);
        if (colq.size() > 0) {col_id, col_le, col_te} = colq[0];
        else {col_id, col_le, col_te} = '0;
    endtask

    task automatic step(input int rd_p, input int evt_p, input int hit_p, input bit do_clear);
        int sz, code;
        bit w, r;
        logic [REC_W-1:0] wd, hd;
        @(negedge clk);
        gcnt++;
        chk(ts_gray == gray_of(gcnt), "R1", "ts_gray", 32'(ts_gray), 32'(gray_of(gcnt)));
        sz = mq.size();
        chk(empty == (sz == 0), "R4", "empty", 32'(empty), 32'(sz == 0));
        chk(full == (sz == DEPTH), "R4", "full", 32'(full), 32'(sz == DEPTH));
        chk(almost_full == (sz >= AFL), "R4", "almost_full", 32'(almost_full), 32'(sz >= AFL));
        chk(busy == (sz >= AFL), "R5", "busy", 32'(busy), 32'(sz >= AFL));
        if (sz >= AFL) chk(freeze == 1'b1, "R5", "freeze at level", 32'(freeze), 32'd1);
        if (sz > 0) begin
            hd = mq[0];
            chk({rd_id, rd_le, rd_te} == hd, "R3", "head record", 32'({rd_id, rd_le, rd_te}), 32'(hd));
        end
        chk(ovf_err == m_ovf, "R8", "ovf_err", 32'(ovf_err), 32'(m_ovf));
        chk(unf_err == m_unf, "R9", "unf_err", 32'(unf_err), 32'(m_unf));
        // R7: hold and clear behaviour of the dummy flag
        if (dp_prev && !clr_prev) chk(dp_present == 1'b1, "R7", "dp held", 32'(dp_present), 32'd1);
        if (dp_prev && clr_prev)  chk(dp_present == 1'b0, "R7", "dp cleared", 32'(dp_present), 32'd0);
        code = read_cmd ? 1 : read_le ? 2 : read_te ? 3 : clear_hit ? 4 : 0;
        if (code == 4) begin
            chk(h1 == 3 && h2 == 2 && h3 == 1 && freeze, "R2", "scan order",
                32'((h3 << 8) | (h2 << 4) | h1), 32'h123);
        end
        if (code == 1) chk(size2 < AFL, "R5", "scan start below level", 32'(size2), 32'(AFL - 1));
        h3 = h2; h2 = h1; h1 = code;
        w = 0; wd = '0;
        if (clear_hit) begin
            w = 1; wd = colq[0];
            void'(colq.pop_front());
        end
        if (dp_present && !dp_prev) begin
            chk(pend, "R6", "marker only when requested", 32'(pend), 32'd1);
            chk(!clear_hit, "R6", "marker not during scan", 32'(clear_hit), 32'd0);
            w = 1;
            wd = {{ID_W{1'b1}}, pend_stamp, TS_W'(evt_cnt)};
            evt_cnt++;
            pend = 0;
        end
        r = ($urandom % 100) < rd_p;
        if (r && sz == 0) m_unf = 1;
        if (w && sz == DEPTH) m_ovf = 1;
        if (r && sz > 0) void'(mq.pop_front());
        if (w && sz < DEPTH) mq.push_back(wd);
        size2 = size1; size1 = sz;
        dp_prev = dp_present;
        rd_en = r;
        dp_clear = dp_present && do_clear;
        clr_prev = dp_clear;
        evt_req = ($urandom % 100) < evt_p;
        if (evt_req && !pend) begin
            pend = 1;
            pend_stamp = ts_gray;
        end
        if ((($urandom % 100) < hit_p) && colq.size() < 24)
            colq.push_back({ID_W'($urandom % 127), TS_W'($urandom), TS_W'($urandom)});
        drive_col();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(ts_gray == '0, "R10", "ts_gray in reset", 32'(ts_gray), 32'd0);
        chk(empty == 1'b1, "R10", "empty in reset", 32'(empty), 32'd1);
        chk({full, almost_full, busy, ovf_err, unf_err} == '0, "R10", "flags in reset",
            32'({full, almost_full, busy, ovf_err, unf_err}), 32'd0);
        chk({freeze, read_cmd, read_le, read_te, clear_hit, dp_present} == '0, "R10",
            "strobes in reset", 32'({freeze, read_cmd, read_le, read_te, clear_hit, dp_present}), 32'd0);
        rst_n = 1'b1;
        gcnt = 0;
        // R6, R8: fill with markers only, no reads, until overflow
        repeat (80) step(0, 60, 0, 1);
        chk(m_ovf, "R8", "overflow reached", 32'(m_ovf), 32'd1);
        // R8 with a read at the same edge: keep filling while draining
        repeat (20) step(50, 80, 0, 1);
        // R9: drain and read past empty
        repeat (40) step(100, 0, 0, 1);
        chk(m_unf, "R9", "underflow reached", 32'(m_unf), 32'd1);
        // R7: hold the dummy flag without clearing
        step(0, 100, 0, 0);
        repeat (8) step(0, 0, 0, 0);
        chk(dp_present == 1'b1, "R7", "dp still held", 32'(dp_present), 32'd1);
        step(0, 0, 0, 1);
        repeat (4) step(0, 0, 0, 1);
        // R6: back-to-back requests, the second one ignored while pending
        repeat (6) step(0, 100, 0, 1);
        repeat (10) step(100, 0, 0, 1);
        // R2, R3, R5: hits with random reads at several densities
        repeat (1200) step(15, 3, 35, 1);
        repeat (1200) step(55, 4, 40, 1);
        repeat (1200) step(85, 3, 30, 1);
        repeat (600)  step(30, 6, 50, 1);
        // drain everything
        repeat (300) step(100, 0, 0, 1);
        chk(colq.size() == 0, "R2", "all pixels served", 32'(colq.size()), 32'd0);
        chk(!pend, "R6", "marker served", 32'(pend), 32'd0);
        chk(mq.size() == 0 && empty, "R4", "drained", 32'(mq.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule